// File: doc/BRIEF.md
# Keyed Watchdog with Prescaled Count Clock

This block is a watchdog timer for a system controller. An 8-bit counter advances on a tick that comes from the oscillator clock after a fixed divide-by-512 stage and then a power-of-two prescaler chosen by a 3-bit select. When the counter wraps, the block drives a watchdog reset output for a fixed number of clock cycles. The watchdog runs from the moment the power-on reset is released.

Software changes the configuration through one control word. Every write must carry the check key `101` in its key field. A write with any other key, while the watchdog runs, is thrown away and fires the reset pulse at once. This lets software force a reset on purpose. The disable bit is locked: it only changes while the override input is high.

A sticky flag records that a watchdog pulse happened. The external reset level passes through a two-stage synchronizer and qualifies the flag. The flag is set a fixed delay after the pulse begins, and only if the external reset is high at that moment. It is held at zero while the external reset is low, so a watchdog reset can be told apart from an external one. Software clears the flag by writing 1 to it.

Top module: `wdk_top`

## Requirements
- R1: After power-on reset, `rd_data` is 0 (enabled, prescale 0, flag 0), `wd_rst_o` is 0 and `cnt_o` is 0.
- R2: A keyed write changes the disable bit (`wr_data[6]`) only when `override_i` is 1 during that write. Otherwise the disable bit keeps its value and the rest of the write still applies.
- R3: A write is accepted only when `wr_data[5:3]` equals `3'b101`. A write with any other key, while enabled, is discarded. On the next clock edge it raises `wd_rst_o` and restarts the counter and prescaler from zero.
- R4: The read layout is `rd_data[7]` = flag, `rd_data[6]` = disable, `rd_data[5:3]` = `000` always, and `rd_data[2:0]` = prescale select.
- R5: With prescale code c in `wr_data[2:0]`, the tick period is BASE_DIV × d clocks. d is 1 for codes 0 and 1, and 2^(c-1) for codes 2 to 7. The first overflow raises `wd_rst_o` exactly 2^CNT_W × BASE_DIV × d edges after reset release.
- R6: Each watchdog pulse keeps `wd_rst_o` high for exactly PULSE_LEN clock cycles. A trigger that arrives during a pulse is ignored.
- R7: While disabled, `cnt_o` holds at 0, and neither overflow nor a bad key produces a pulse. A bad-key write while disabled leaves the register unchanged.
- R8: The flag rises FLAG_DLY+1 edges after the edge that raises `wd_rst_o`, provided the synchronized external reset is high then.
- R9: `ext_rst_n` passes through a two-flop synchronizer. While the synchronized level is low, the flag is held at 0. A pending set is dropped if that level is low at the set time.
- R10: An accepted write with `wr_data[7]` = 1 clears the flag on that edge.
- R11: `cnt_o` advances by one per tick and wraps from all-ones to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator/system clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| ext_rst_n | input | 1 | External reset level, asynchronous |
| override_i | input | 1 | Unlocks the disable bit |
| wr_en | input | 1 | Control write strobe |
| wr_data | input | 8 | Write word: [7] flag clear, [6] disable, [5:3] key, [2:0] prescale |
| rd_data | output | 8 | Read word: [7] flag, [6] disable, [5:3] zero, [2:0] prescale |
| cnt_o | output | CNT_W | Watchdog counter value |
| wd_rst_o | output | 1 | Watchdog reset pulse |

## Verification
Timing is counted in clock edges from the first edge after reset release. That edge also applies the configuring write. Register updates are due on the edge that samples the write. A bad key raises `wd_rst_o` on that same edge. An overflow raises it at edge 2^CNT_W × BASE_DIV × d, the pulse falls PULSE_LEN edges later, and the flag rises FLAG_DLY+1 edges after the pulse. A change on `ext_rst_n` reaches the flag three edges later. The bench tracks the edge count, samples 1 ns after an edge, and checks each output on the edge where it is due and on the edge just before.

// File: rtl/wdk_pkg.sv
// Shared constants and helpers for the keyed watchdog.
// Assumes an 8-bit control word with fixed field positions.
package wdk_pkg;
    localparam logic [2:0] CHECK_KEY = 3'b101;
    localparam int         FLAG_BIT  = 7;
    localparam int         DIS_BIT   = 6;
    localparam int         KEY_HI    = 5;
    localparam int         KEY_LO    = 3;
    localparam int         PSEL_W    = 3;
    localparam int         PDIV_W    = 6;

    // Prescale code to log2 of the extra divide (codes 0 and 1 both mean 1).
    function automatic logic [2:0] div_shift(input logic [2:0] code);
        return (code < 3'd2) ? 3'd0 : code - 3'd1;
    endfunction
endpackage

// File: rtl/wdk_prescale.sv
// Two-stage tick generator: a fixed base divider, then a power-of-two divider
// picked by the prescale code. Assumes BASE_DIV >= 2. Both stages clear when
// run is low or restart is high.
module wdk_prescale #(
    parameter int BASE_DIV = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [2:0] psel,
    output logic       tick
);
    import wdk_pkg::*;
    localparam int BW = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
    localparam logic [BW-1:0] BASE_LAST = BW'(BASE_DIV - 1);

    logic [BW-1:0]     base_q;
    logic [PDIV_W-1:0] pdiv_q;
    logic [PDIV_W-1:0] mask;
    logic              base_wrap;

    assign base_wrap = (base_q == BASE_LAST);

    // Mask of low divider bits that must all be ones for a tick.
    always_comb begin
        mask = PDIV_W'((7'd1 << div_shift(psel)) - 7'd1);
    end

    // Advance the base divider and count its wraps in the second stage.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            base_q <= '0;
            pdiv_q <= '0;
        end else if (base_wrap) begin
            base_q <= '0;
            pdiv_q <= pdiv_q + 1'b1;
        end else begin
            base_q <= base_q + 1'b1;
        end
    end

    assign tick = run && !restart && base_wrap && ((pdiv_q & mask) == mask);
endmodule

// File: rtl/wdk_core.sv
// Watchdog counter and reset-pulse generator. The counter counts ticks and
// wraps; a wrap or a kick starts a pulse of PULSE_LEN cycles unless one is
// already running. Assumes PULSE_LEN >= 2.
module wdk_core #(
    parameter int CNT_W     = 8,
    parameter int PULSE_LEN = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             tick,
    input  logic             kick,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wd_rst_o
);
    localparam int PW = $clog2(PULSE_LEN);
    localparam logic [PW-1:0] PULSE_LAST = PW'(PULSE_LEN - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [PW-1:0]    plen_q;
    logic             active_q;
    logic             trigger;

    assign trigger = (tick && (cnt_q == '1)) || kick;

    // Count prescaled ticks; clear while stopped or restarted.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Shape the fixed-length reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            plen_q   <= '0;
        end else if (trigger && !active_q) begin
            active_q <= 1'b1;
            plen_q   <= '0;
        end else if (active_q) begin
            if (plen_q == PULSE_LAST) begin
                active_q <= 1'b0;
            end else begin
                plen_q <= plen_q + 1'b1;
            end
        end
    end

    assign cnt_o    = cnt_q;
    assign wd_rst_o = active_q;

    // R6
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_q) |=> active_q);
endmodule

// File: rtl/wdk_flag.sv
// Reset-source flag. Synchronizes the external reset level, detects the rise
// of the watchdog pulse, waits FLAG_DLY cycles, then sets the flag if the
// external level is high. The flag is held low while that level is low.
module wdk_flag #(
    parameter int FLAG_DLY = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_rst_n,
    input  logic wd_rst,
    input  logic clr,
    output logic flag_o
);
    localparam int DW = $clog2(FLAG_DLY);
    localparam logic [DW-1:0] DLY_LAST = DW'(FLAG_DLY - 1);

    logic          sync1_q, sync2_q;
    logic          wd_q;
    logic          busy_q;
    logic [DW-1:0] dly_q;
    logic          flag_q;
    logic          set_now;

    // Two-flop synchronizer for the external reset level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= ext_rst_n;
            sync2_q <= sync1_q;
        end
    end

    // Remember the previous pulse level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) wd_q <= 1'b0;
        else        wd_q <= wd_rst;
    end

    // Delay line from the pulse rise to the set point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            dly_q  <= '0;
        end else if (wd_rst && !wd_q) begin
            busy_q <= 1'b1;
            dly_q  <= '0;
        end else if (busy_q) begin
            if (dly_q == DLY_LAST) busy_q <= 1'b0;
            else                   dly_q  <= dly_q + 1'b1;
        end
    end

    assign set_now = busy_q && (dly_q == DLY_LAST);

    // Sticky flag: forced low by external reset, set after the delay, W1C.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (!sync2_q) flag_q <= 1'b0;
        else if (set_now) flag_q <= 1'b1;
        else if (clr)     flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // R8
    flag_needs_ext_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(sync2_q));
    // R9
    flag_held_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync2_q && !flag_q) |=> !flag_q);
endmodule

// File: rtl/wdk_top.sv
// Keyed watchdog top. Holds the control word (disable, prescale), checks the
// key on every write, and ties the prescaler, counter and flag together.
// Assumes one clock for oscillator and system timing.
module wdk_top #(
    parameter int BASE_DIV  = 512,
    parameter int CNT_W     = 8,
    parameter int PULSE_LEN = 512,
    parameter int FLAG_DLY  = 8192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_rst_n,
    input  logic             override_i,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wd_rst_o
);
    import wdk_pkg::*;

    logic       dis_q;
    logic [2:0] psel_q;
    logic       key_ok, wr_ok, bad_key;
    logic       tick, flag;

    assign key_ok  = (wr_data[KEY_HI:KEY_LO] == CHECK_KEY);
    assign wr_ok   = wr_en && key_ok;
    assign bad_key = wr_en && !key_ok && !dis_q;

    // Control word update on accepted writes; disable bit needs override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_q  <= 1'b0;
            psel_q <= '0;
        end else if (wr_ok) begin
            psel_q <= wr_data[PSEL_W-1:0];
            if (override_i) dis_q <= wr_data[DIS_BIT];
        end
    end

    wdk_prescale #(.BASE_DIV(BASE_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(!dis_q), .restart(bad_key),
        .psel(psel_q), .tick(tick)
    );

    wdk_core #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_core (
        .clk(clk), .rst_n(rst_n), .run(!dis_q), .restart(bad_key),
        .tick(tick), .kick(bad_key), .cnt_o(cnt_o), .wd_rst_o(wd_rst_o)
    );

    wdk_flag #(.FLAG_DLY(FLAG_DLY)) u_flag (
        .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .wd_rst(wd_rst_o),
        .clr(wr_ok && wr_data[FLAG_BIT]), .flag_o(flag)
    );

    assign rd_data = {flag, dis_q, 3'b000, psel_q};

    // R2
    dis_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dis_q) |-> $past(override_i));
    // R3
    bad_key_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_key && !wd_rst_o) |=> wd_rst_o);
    // R7
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_q && $past(dis_q) && !$past(wd_rst_o)) |-> !wd_rst_o);
    // R7
    disabled_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_q && $past(dis_q)) |-> (cnt_o == '0));
endmodule

// File: tb/wdk_top_tb.sv
`timescale 1ns/1ps
module wdk_top_tb;
    localparam int B = 4, W = 3, P = 5, D = 20;
    localparam int N0 = (1 << W) * B;

    logic       clk = 0, rst_n = 0, ext_rst_n = 1, override_i = 0, wr_en = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic [W-1:0] cnt_o;
    logic       wd_rst_o;
    int n_chk = 0, n_bad = 0, pos = 0;

    always #2.5 clk = ~clk;

    wdk_top #(.BASE_DIV(B), .CNT_W(W), .PULSE_LEN(P), .FLAG_DLY(D)) u_dut (
        .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .override_i(override_i),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .cnt_o(cnt_o),
        .wd_rst_o(wd_rst_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at edge %0d: actual %0d expected %0d", req, pos, act, exp);
        end
    endtask

    task automatic at(input int t);
        repeat (t - pos) @(posedge clk);
        pos = t;
        #1;
    endtask

    // Reset, then release with a write applied on edge 1.
    task automatic start(input logic [7:0] w);
        @(negedge clk); rst_n = 0; wr_en = 0;
        repeat (3) @(negedge clk);
        @(negedge clk); rst_n = 1; wr_en = 1; wr_data = w; pos = 0;
        @(posedge clk); pos = 1; #1; wr_en = 0;
    endtask

    task automatic wr(input logic [7:0] w);
        wr_en = 1; wr_data = w;
        at(pos + 1);
        wr_en = 0;
    endtask

    function automatic logic [7:0] word(input bit clr, input bit dis,
                                        input logic [2:0] key, input logic [2:0] ps);
        return {clr, dis, key, ps};
    endfunction

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: state while held in reset
        repeat (3) @(posedge clk); #1;
        check("R1 rd_data", rd_data, 0);
        check("R1 wd_rst_o", wd_rst_o, 0);
        check("R1 cnt_o", cnt_o, 0);

        // R5/R6/R8/R4 sweep over every prescale code
        for (int c = 0; c < 8; c++) begin
            int dv, n;
            dv = (c < 2) ? 1 : (1 << (c - 1));
            n  = N0 * dv;
            start(word(0, 0, 3'b101, 3'(c)));
            check("R4 key reads zero", rd_data, c);
            if (c == 0) begin
                at(B - 1);   check("R11 cnt before tick", cnt_o, 0);
                at(B);       check("R11 cnt first tick", cnt_o, 1);
                at(7 * B);   check("R11 cnt top", cnt_o, 7);
                at(8 * B);   check("R11 cnt wrap", cnt_o, 0);
            end else begin
                at(n - 1);   check("R5 no pulse yet", wd_rst_o, 0);
                at(n);
            end
            check("R5 pulse on overflow", wd_rst_o, 1);
            at(n + P - 1); check("R6 pulse still high", wd_rst_o, 1);
            at(n + P);     check("R6 pulse ended", wd_rst_o, 0);
            at(n + D);     check("R8 flag not yet", rd_data[7], 0);
            at(n + D + 1); check("R8 flag set", rd_data[7], 1);
        end

        // R2 / R7: disable lock and disabled behaviour
        start(word(0, 0, 3'b101, 3'd0));
        at(2);
        override_i = 0; wr(word(0, 1, 3'b101, 3'd2));
        check("R2 dis locked", rd_data, 2);
        override_i = 1; wr(word(0, 1, 3'b101, 3'd0));
        check("R2 dis written", rd_data, 8'h40);
        override_i = 0;
        at(pos + 200);
        check("R7 cnt held", cnt_o, 0);
        check("R7 no overflow pulse", wd_rst_o, 0);
        wr(word(0, 0, 3'b011, 3'd3));
        check("R7 bad key no pulse", wd_rst_o, 0);
        check("R7 bad key ignored", rd_data, 8'h40);
        at(pos + 3); check("R7 still quiet", wd_rst_o, 0);
        wr(word(0, 0, 3'b101, 3'd0));
        check("R2 enable locked", rd_data[6], 1);

        // R3: bad key while enabled
        start(word(0, 0, 3'b101, 3'd0));
        at(10);
        wr(word(0, 1, 3'b110, 3'd2));
        check("R3 immediate pulse", wd_rst_o, 1);
        check("R3 write discarded", rd_data, 0);
        check("R3 counter restarted", cnt_o, 0);
        at(11 + P - 1); check("R6 kick pulse high", wd_rst_o, 1);
        at(11 + P);     check("R6 kick pulse low", wd_rst_o, 0);
        at(11 + N0 - 1); check("R3 restart no overflow", wd_rst_o, 0);
        at(11 + N0);     check("R3 restart overflow", wd_rst_o, 1);

        // R9 / R10: external reset qualification and clear
        start(word(0, 0, 3'b101, 3'd0));
        at(N0 + P + 2); ext_rst_n = 0;
        at(N0 + D + 1); check("R9 set dropped", rd_data[7], 0);
        at(60); ext_rst_n = 1;
        at(70); check("R9 still clear", rd_data[7], 0);
        at(2 * N0 + D + 1); check("R8 second set", rd_data[7], 1);
        ext_rst_n = 0;
        at(2 * N0 + D + 3); check("R9 sync delay", rd_data[7], 1);
        at(2 * N0 + D + 4); check("R9 forced low", rd_data[7], 0);
        ext_rst_n = 1;
        at(3 * N0 + D + 1); check("R8 third set", rd_data[7], 1);
        wr(word(1, 0, 3'b101, 3'd0));
        check("R10 flag cleared", rd_data[7], 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule